// File: doc/BRIEF.md
# Port-Mapped Memory Word Access Unit

This unit sits on the narrow I/O bus of a small microcontroller and gives software a way to reach single words of a large word-addressed memory. Software assembles a word address and a write word a byte at a time through bus output ports. It then writes a command byte that starts either a write or a read. The unit turns the command into a request toward the memory arbiter and keeps flags that software polls through a status input port. Returned read data is latched and read back a byte at a time.

A request stays raised until the arbiter signals, through an early "operation started" strobe, that it has taken the operation. Taking a write clears the write-pending flag. A read stays pending until its data comes back. At that point the data is latched, the read-pending flag clears and the read-done flag sets, all on the same edge. The read-done flag is cleared by rewriting any address byte, so a fresh address always invalidates old data. Commands that arrive while an operation is pending are dropped.

Only the low port-ID bits are decoded. The bit just above the port index must be zero for this unit to respond, and all higher bits are ignored.

Top module: `pmem_portbank`

## Requirements
- R1: After reset, the write-pending, read-pending and read-done flags are 0, `mem_req` is 0, and the address, write-word and read-data registers are 0.
- R2: On a strobed write, output ports 0, 1 and 2 load the low, middle and high address bytes, and ports 3 and 4 load the low and high write-word bytes. The new value appears on `mem_addr` / `mem_wdata` after that clock edge.
- R3: The unit responds only when `pid[3]` is 0, and `pid[7:4]` is ignored. A strobed write with `pid[3]`=1 changes nothing, and a read with `pid[3]`=1 returns 0.
- R4: A write to command port 5 with bit 0 (write) set raises the write-pending flag (status bit 2) and raises `mem_req` with `mem_we`=1 after that edge.
- R5: A command with bit 1 (read) set and bit 0 clear raises the read-pending flag (status bit 1) and `mem_req` with `mem_we`=0. A command with both bits set is a write only. The two pending flags are never set together.
- R6: `mem_begun` sampled while `mem_req` is high drops `mem_req` on that edge. For a write it also clears the write-pending flag; for a read the read-pending flag stays set.
- R7: `mem_rd_valid` sampled while read-pending latches `mem_rdata`, clears read-pending and sets read-done (status bit 0) on the same edge. `mem_rd_valid` with no read pending changes no flag and no latched data.
- R8: A strobed write to any address byte port clears read-done on that edge. If returned read data is latched on the same edge, read-done is set instead.
- R9: A command written while either pending flag is set is ignored.
- R10: Input port 0 returns the low read-data byte, port 1 the high byte, and port 2 the status byte {5'b0, write-pending, read-pending, read-done}. Ports 3 to 7 return 0. `in_data` follows `pid` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid | input | 8 | Port ID from the microcontroller |
| out_data | input | 8 | Byte written by the microcontroller |
| wr_strobe | input | 1 | Output-port write strobe |
| in_data | output | 8 | Byte returned for the selected input port |
| mem_req | output | 1 | Request toward the memory arbiter |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 16 | Word to write |
| mem_begun | input | 1 | Arbiter has started the requested operation |
| mem_rd_valid | input | 1 | Read data is present on `mem_rdata` |
| mem_rdata | input | 16 | Returned read word |

## Verification
The bench builds the unit with its default parameters: an 8-bit bus and port ID, select bit 3, a 24-bit address and a 16-bit word. With these values there are three address-byte ports, two write-word ports and one command port, so every output port index below 6 is used. The three input ports leave indices 3 to 7 to read as zero. An 8-bit ID with select bit 3 leaves four upper bits free, so the bench can probe aliasing through them alongside the deselect bit. The bench also drives the arbiter strobes by hand to force the same-edge cases: a return colliding with an address write, and stray returns or commands while busy.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
   // status byte bit positions
   localparam int ST_DONE = 0;
   localparam int ST_RDP  = 1;
   localparam int ST_WRP  = 2;
   // command byte bit positions
   localparam int CMD_WR  = 0;
   localparam int CMD_RD  = 1;

   typedef struct packed {
      logic wrp;   // write pending
      logic rdp;   // read pending
      logic done;  // read data ready
   } pmb_flags_t;
endpackage

// File: rtl/pmb_decode.sv
module pmb_decode #(
   parameter int SEL_BIT = 3,
   localparam int NPORT  = 2 ** SEL_BIT
) (
   input  logic [SEL_BIT:0]   pid_lo,
   input  logic               wr_strobe,
   output logic [NPORT-1:0]   wr_hit,
   output logic               rd_sel,
   output logic [SEL_BIT-1:0] rd_idx
);
   assign rd_sel = ~pid_lo[SEL_BIT];
   assign rd_idx = pid_lo[SEL_BIT-1:0];

   for (genvar i = 0; i < NPORT; i++) begin : g_hit
      assign wr_hit[i] = wr_strobe & rd_sel & (rd_idx == SEL_BIT'(i));
   end
endmodule

// File: rtl/pmb_bytereg.sv
module pmb_bytereg #(
   parameter int BUS_W  = 8,
   parameter int OUT_W  = 24,
   localparam int NBYTE = (OUT_W + BUS_W - 1) / BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBYTE-1:0] we,
   input  logic [BUS_W-1:0] din,
   output logic [OUT_W-1:0] q
);
   logic [NBYTE*BUS_W-1:0] store;

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            store[b*BUS_W +: BUS_W] <= '0;
         else if (we[b])
            store[b*BUS_W +: BUS_W] <= din;
      end
   end

   if (NBYTE * BUS_W == OUT_W) begin : g_exact
      assign q = store;
   end else begin : g_trim
      logic [NBYTE*BUS_W-OUT_W-1:0] unused_pad;
      assign unused_pad = store[NBYTE*BUS_W-1:OUT_W];
      assign q = store[OUT_W-1:0];
   end
endmodule

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
   import pmb_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic              cmd_wr,
   input  logic              cmd_rd,
   input  logic              addr_we,
   input  logic              mem_begun,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output pmb_flags_t        flags,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] rdata
);
   logic busy, accept, taken, ret;

   assign busy   = flags.wrp | flags.rdp;
   assign accept = cmd_we & ~busy & (cmd_wr | cmd_rd);
   assign taken  = mem_req & mem_begun;
   assign ret    = flags.rdp & mem_rd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags   <= '0;
         mem_req <= 1'b0;
         mem_we  <= 1'b0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            mem_req <= 1'b1;
            mem_we  <= cmd_wr;
            if (cmd_wr) flags.wrp <= 1'b1;
            else        flags.rdp <= 1'b1;
         end else if (taken) begin
            mem_req <= 1'b0;
            if (mem_we) flags.wrp <= 1'b0;
         end
         if (ret) begin
            rdata      <= mem_rdata;
            flags.rdp  <= 1'b0;
            flags.done <= 1'b1;
            if (!mem_we) mem_req <= 1'b0;
         end else if (addr_we) begin
            flags.done <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pmem_portbank.sv
module pmem_portbank
   import pmb_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int PID_W   = 8,
   parameter int SEL_BIT = 3,
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PID_W-1:0]  pid,
   input  logic [BUS_W-1:0]  out_data,
   input  logic              wr_strobe,
   output logic [BUS_W-1:0]  in_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_begun,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int NPORT      = 2 ** SEL_BIT;
   localparam int ADDR_BYTES = (ADDR_W + BUS_W - 1) / BUS_W;
   localparam int DATA_BYTES = (DATA_W + BUS_W - 1) / BUS_W;
   localparam int WD_BASE    = ADDR_BYTES;
   localparam int CMD_PORT   = ADDR_BYTES + DATA_BYTES;
   localparam int STAT_PORT  = DATA_BYTES;

   // elaboration-time parameter checks
   if (SEL_BIT < 1 || SEL_BIT + 1 > PID_W) begin : g_bad_sel
      $error("pmem_portbank: SEL_BIT out of range");
   end
   if (CMD_PORT + 1 > NPORT) begin : g_bad_wports
      $error("pmem_portbank: too many output ports for SEL_BIT");
   end
   if (STAT_PORT + 1 > NPORT) begin : g_bad_rports
      $error("pmem_portbank: too many input ports for SEL_BIT");
   end
   if (BUS_W < 3) begin : g_bad_bus
      $error("pmem_portbank: bus too narrow for status byte");
   end

   logic [NPORT-1:0]   wr_hit;
   logic               rd_sel;
   logic [SEL_BIT-1:0] rd_idx;
   logic               addr_we;
   pmb_flags_t         flags;
   logic [DATA_W-1:0]  rdata;
   logic               unused_bits;

   pmb_decode #(.SEL_BIT(SEL_BIT)) u_dec (
      .pid_lo   (pid[SEL_BIT:0]),
      .wr_strobe(wr_strobe),
      .wr_hit   (wr_hit),
      .rd_sel   (rd_sel),
      .rd_idx   (rd_idx)
   );

   if (PID_W > SEL_BIT + 1) begin : g_hi_pid
      assign unused_bits = ^{pid[PID_W-1:SEL_BIT+1], wr_hit};
   end else begin : g_no_hi_pid
      assign unused_bits = ^wr_hit;
   end

   assign addr_we = |wr_hit[ADDR_BYTES-1:0];

   pmb_bytereg #(.BUS_W(BUS_W), .OUT_W(ADDR_W)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_hit[ADDR_BYTES-1:0]),
      .din  (out_data),
      .q    (mem_addr)
   );

   pmb_bytereg #(.BUS_W(BUS_W), .OUT_W(DATA_W)) u_wdat (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_hit[CMD_PORT-1:WD_BASE]),
      .din  (out_data),
      .q    (mem_wdata)
   );

   pmb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (wr_hit[CMD_PORT]),
      .cmd_wr      (out_data[CMD_WR]),
      .cmd_rd      (out_data[CMD_RD]),
      .addr_we     (addr_we),
      .mem_begun   (mem_begun),
      .mem_rd_valid(mem_rd_valid),
      .mem_rdata   (mem_rdata),
      .flags       (flags),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .rdata       (rdata)
   );

   // input port view
   logic [DATA_BYTES*BUS_W-1:0] rd_pad;
   logic [BUS_W-1:0]            rport [NPORT];
   logic                        st_wrp, st_rdp, st_done;

   assign rd_pad  = (DATA_BYTES*BUS_W)'(rdata);
   assign st_wrp  = flags.wrp;
   assign st_rdp  = flags.rdp;
   assign st_done = flags.done;

   for (genvar i = 0; i < NPORT; i++) begin : g_rport
      if (i < DATA_BYTES) begin : g_data
         assign rport[i] = rd_pad[i*BUS_W +: BUS_W];
      end else if (i == STAT_PORT) begin : g_stat
         always_comb begin
            rport[i]          = '0;
            rport[i][ST_WRP]  = st_wrp;
            rport[i][ST_RDP]  = st_rdp;
            rport[i][ST_DONE] = st_done;
         end
      end else begin : g_zero
         assign rport[i] = '0;
      end
   end

   assign in_data = rd_sel ? rport[rd_idx] : '0;
endmodule

// File: rtl/pmb_checker.sv
module pmb_checker (
   input logic clk,
   input logic rst_n,
   input logic mem_req,
   input logic mem_we,
   input logic mem_begun,
   input logic mem_rd_valid,
   input logic wrp,
   input logic rdp,
   input logic done,
   input logic addr_we
);
   // R4
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (wrp || rdp));

   // R5
   pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wrp && rdp));

   // R6
   wr_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_begun) |=> (!wrp && !mem_req));

   // R7
   rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdp && mem_rd_valid) |=> (done && !rdp));

   // R8
   addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_we && !(rdp && mem_rd_valid)) |=> !done);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wrp || rdp) && !mem_begun && !mem_rd_valid) |=> $stable({wrp, rdp, mem_we}));
endmodule

bind pmem_portbank pmb_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_begun   (mem_begun),
   .mem_rd_valid(mem_rd_valid),
   .wrp         (st_wrp),
   .rdp         (st_rdp),
   .done        (st_done),
   .addr_we     (addr_we)
);

// File: tb/pmem_portbank_bench.sv
module pmem_portbank_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pid = '0;
   logic [7:0]  out_data = '0;
   logic        wr_strobe = 1'b0;
   logic [7:0]  in_data;
   logic        mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_begun = 1'b0;
   logic        mem_rd_valid = 1'b0;
   logic [15:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmem_portbank u_pmem_portbank (
      .clk(clk), .rst_n(rst_n), .pid(pid), .out_data(out_data),
      .wr_strobe(wr_strobe), .in_data(in_data), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_begun(mem_begun), .mem_rd_valid(mem_rd_valid),
      .mem_rdata(mem_rdata)
   );

   // {pid, byte, expected address, expected write word}
   localparam logic [55:0] VEC [8] = '{
      {8'h00, 8'h11, 24'h000011, 16'h0000},
      {8'h01, 8'h22, 24'h002211, 16'h0000},
      {8'h02, 8'h33, 24'h332211, 16'h0000},
      {8'h03, 8'h44, 24'h332211, 16'h0044},
      {8'h04, 8'h55, 24'h332211, 16'h5544},
      {8'h0A, 8'h99, 24'h332211, 16'h5544},
      {8'hF1, 8'h77, 24'h337711, 16'h5544},
      {8'h0C, 8'hAA, 24'h337711, 16'h5544}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] p, input logic [7:0] v);
      @(negedge clk);
      pid = p; out_data = v; wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
   endtask

   task automatic rd_port(input logic [7:0] p, output logic [7:0] v);
      pid = p;
      #1;
      v = in_data;
   endtask

   task automatic pulse_begun();
      @(negedge clk);
      mem_begun = 1'b1;
      @(negedge clk);
      mem_begun = 1'b0;
   endtask

   task automatic pulse_ret(input logic [15:0] d);
      @(negedge clk);
      mem_rdata = d; mem_rd_valid = 1'b1;
      @(negedge clk);
      mem_rd_valid = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_port(8'h02, v);
      chk("R1 status", v, 8'h00);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 mem_addr", mem_addr, 0);
      chk("R1 mem_wdata", mem_wdata, 0);
      rd_port(8'h00, v);
      chk("R1 rdata lo", v, 8'h00);

      // R2 R3 table of register writes
      for (int i = 0; i < 8; i++) begin
         bus_wr(VEC[i][55:48], VEC[i][47:40]);
         chk("R2/R3 mem_addr", mem_addr, VEC[i][39:16]);
         chk("R2/R3 mem_wdata", mem_wdata, VEC[i][15:0]);
      end

      // R4 write command
      bus_wr(8'h05, 8'h01);
      rd_port(8'h02, v);
      chk("R4 status", v, 8'h04);
      chk("R4 mem_req", mem_req, 1);
      chk("R4 mem_we", mem_we, 1);
      // R9 command while busy dropped
      bus_wr(8'h05, 8'h02);
      rd_port(8'h02, v);
      chk("R9 status", v, 8'h04);
      chk("R9 mem_we", mem_we, 1);
      // R6 write taken
      pulse_begun();
      rd_port(8'h02, v);
      chk("R6 wr status", v, 8'h00);
      chk("R6 wr mem_req", mem_req, 0);

      // R5 read command
      bus_wr(8'h05, 8'h02);
      rd_port(8'h02, v);
      chk("R5 status", v, 8'h02);
      chk("R5 mem_req", mem_req, 1);
      chk("R5 mem_we", mem_we, 0);
      pulse_begun();
      rd_port(8'h02, v);
      chk("R6 rd status keeps pending", v, 8'h02);
      chk("R6 rd mem_req", mem_req, 0);
      // R7 data return
      pulse_ret(16'hBEEF);
      rd_port(8'h02, v);
      chk("R7 status", v, 8'h01);
      rd_port(8'h00, v);
      chk("R7 R10 rdata lo", v, 8'hEF);
      rd_port(8'h01, v);
      chk("R7 R10 rdata hi", v, 8'hBE);
      rd_port(8'h90, v);
      chk("R3 alias read", v, 8'hEF);
      rd_port(8'h08, v);
      chk("R3 deselected read", v, 8'h00);
      rd_port(8'h03, v);
      chk("R10 empty port", v, 8'h00);
      // R8 address write clears done
      bus_wr(8'h02, 8'h33);
      rd_port(8'h02, v);
      chk("R8 status", v, 8'h00);

      // R5 both bits -> write
      bus_wr(8'h05, 8'h03);
      rd_port(8'h02, v);
      chk("R5 both status", v, 8'h04);
      chk("R5 both mem_we", mem_we, 1);
      pulse_begun();
      // R7 stray return ignored
      pulse_ret(16'h1234);
      rd_port(8'h02, v);
      chk("R7 stray status", v, 8'h00);
      rd_port(8'h00, v);
      chk("R7 stray data kept", v, 8'hEF);

      // R8 return and address write on the same edge
      bus_wr(8'h05, 8'h02);
      pulse_begun();
      @(negedge clk);
      pid = 8'h00; out_data = 8'h5A; wr_strobe = 1'b1;
      mem_rdata = 16'hC0DE; mem_rd_valid = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0; mem_rd_valid = 1'b0;
      rd_port(8'h02, v);
      chk("R8 set wins status", v, 8'h01);
      chk("R8 addr loaded", mem_addr, 24'h33775A);
      rd_port(8'h01, v);
      chk("R8 rdata hi", v, 8'hC0);

      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule